// File: doc/BRIEF.md
# Translation Context Register Bank

This block holds the software-visible control and fault state for a small I/O address translation unit. It has a parameterised number of translation contexts (four by default). Each context has three registers: a control register, a fault status register and a fault address register. Software reaches them over a simple 32-bit register bus with APB-style timing: `bus_sel` marks a transfer, `bus_enable` marks its access phase, and `bus_ready` is always high. Reads return data in the access phase without a wait state. Each context occupies a window of 0x40 bytes, and the context number is taken from the address bits just above that window.

On the engine side, each context has its own flush request line and flush completion line. The translation engine reports faults through a single strobed record that names the context, the fault kinds, an error code, the table level and the faulting I/O address. The engine may present at most one fault record per cycle. The record is a plain strobe with no back-pressure, and the bank always accepts it in the cycle it is presented.

Two rules are unusual. First, the flush bit in the control register keeps reading as 1 until the engine reports completion. Second, the fault status is cleared by writing an all-zero word; writing ones does nothing. The interrupt output is a level that stays high while any context has both its interrupt enable set and at least one fault flag set.

Top module: `xlat_ctx_regbank`

## Requirements
- R1: After reset, every register of every context reads 0, `irq` is low and every `flush_req` line is low.
- R2: The context number is taken from address bits [7:6]. Within a context, offset 0x00 selects control, 0x20 selects status and 0x30 selects the fault address. Any other offset reads as 0, and writes to it change no register.
- R3: The control register stores bit 0 (translate enable), bit 2 (interrupt enable), bit 16 (access-flag handling) and bit 17 (remapping), and reads them back. Every other bit reads as 0, except the flush bit described in R4.
- R4: Writing 1 to control bit 1 produces a one-cycle pulse on that context's `flush_req` line in the cycle after the write. Control bit 1 then reads as 1 until a `flush_done` pulse arrives for that context, and reads as 0 from the next cycle onward.
- R5: Writing control bit 1 while a flush is already pending produces no second `flush_req` pulse. The pending flush stays set.
- R6: A fault record captured while the context has no fault flags set stores all of its fields. The flags go to status bit 0 (translation fault), bit 1 (page fault), bit 2 (walk abort) and bit 4 (multiple hit). The error code goes to status bits 10:8 and the table level to bits 13:12. The address is stored in the fault address register.
- R7: A fault record arriving while flags are already set only ORs its flags into the status. The stored error code, level and address are kept.
- R8: A status write with data equal to zero clears the flags, the error code, the level and the fault address. A status write with any nonzero data changes nothing.
- R9: The fault address register reads as 0 whenever the context has no fault flag set.
- R10: `irq` is high exactly while at least one context has its interrupt enable bit set and at least one fault flag set.
- R11: Writing zero to a control register clears its enable bits. A flush that is already pending stays pending until `flush_done` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Transfer select |
| bus_enable | input | 1 | Access phase marker |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access phase |
| bus_ready | output | 1 | Always 1 |
| flush_req | output | 4 | One-cycle flush request, one line per context |
| flush_done | input | 4 | One-cycle flush completion, one line per context |
| flt_valid | input | 1 | Fault record strobe |
| flt_ctx | input | 2 | Context the fault belongs to |
| flt_kind | input | 4 | Fault kinds: [0] translation, [1] page, [2] walk abort, [3] multiple hit |
| flt_code | input | 3 | Error code |
| flt_level | input | 2 | Table level of the fault |
| flt_addr | input | 32 | Faulting I/O address |
| irq | output | 1 | Level interrupt |

## Verification
Control writes use all-ones data, to separate the stored bits from the bits that must read as 0, and the same all-ones data goes to an unmapped offset to confirm that nothing lands there. Flushes are tried three ways: a single request, a second request written while the first is pending, and a zero write issued mid-flush. Together these separate pulse generation, pending-state tracking and the disable path. Faults are injected as a first record followed by a second record with different code, level and address, which shows whether the capture keeps the first record or the latest one. Status writes of a nonzero value and of zero then show the write-zero clear rule and the zeroing of the fault address. Interrupt checks run with the interrupt enable both off and on.

// File: rtl/xlat_ctx_pkg.sv
package xlat_ctx_pkg;
  localparam int unsigned WIN_BITS   = 6;
  localparam logic [5:0] OFS_CTRL    = 6'h00;
  localparam logic [5:0] OFS_STAT    = 6'h20;
  localparam logic [5:0] OFS_FADDR   = 6'h30;

  localparam int unsigned B_EN       = 0;
  localparam int unsigned B_FLUSH    = 1;
  localparam int unsigned B_IE       = 2;
  localparam int unsigned B_AF       = 16;
  localparam int unsigned B_RMP      = 17;

  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_STAT, SEL_FADDR} reg_sel_e;

  function automatic logic [31:0] pack_status(input logic [3:0] f,
                                              input logic [2:0] code,
                                              input logic [1:0] lvl);
    logic [31:0] s;
    s        = '0;
    s[2:0]   = f[2:0];
    s[4]     = f[3];
    s[10:8]  = code;
    s[13:12] = lvl;
    return s;
  endfunction
endpackage

// File: rtl/xlat_ctx_decode.sv
module xlat_ctx_decode
  import xlat_ctx_pkg::*;
#(
  parameter int unsigned NCTX = 4,
  parameter int unsigned AW   = 8,
  localparam int unsigned CIW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            bus_sel,
  input  logic            bus_enable,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  output logic [NCTX-1:0] wr_ctrl,
  output logic [NCTX-1:0] wr_stat,
  output logic [CIW-1:0]  rd_ctx,
  output reg_sel_e        rd_sel
);
  logic            access;
  logic [5:0]      ofs;
  logic [CIW-1:0]  ctx;
  reg_sel_e        sel;

  assign access = bus_sel & bus_enable;
  assign ofs    = bus_addr[WIN_BITS-1:0];
  assign ctx    = bus_addr[WIN_BITS +: CIW];

  always_comb begin
    if (int'(ctx) >= NCTX)      sel = SEL_NONE;
    else if (ofs == OFS_CTRL)   sel = SEL_CTRL;
    else if (ofs == OFS_STAT)   sel = SEL_STAT;
    else if (ofs == OFS_FADDR)  sel = SEL_FADDR;
    else                        sel = SEL_NONE;
  end

  for (genvar i = 0; i < NCTX; i++) begin : g_wr
    assign wr_ctrl[i] = access & bus_write & (ctx == CIW'(i)) & (sel == SEL_CTRL);
    assign wr_stat[i] = access & bus_write & (ctx == CIW'(i)) & (sel == SEL_STAT);
  end

  assign rd_ctx = ctx;
  assign rd_sel = sel;
endmodule

// File: rtl/xlat_ctx_slice.sv
module xlat_ctx_slice
  import xlat_ctx_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned IAW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctrl,
  input  logic           wr_stat,
  input  logic [DW-1:0]  wdata,
  input  logic           flush_done,
  input  logic           flt_hit,
  input  logic [3:0]     flt_kind,
  input  logic [2:0]     flt_code,
  input  logic [1:0]     flt_level,
  input  logic [IAW-1:0] flt_addr,
  output logic [31:0]    ctrl_rd,
  output logic [31:0]    stat_rd,
  output logic [IAW-1:0] faddr_rd,
  output logic           flush_req,
  output logic           irq_src
);
  logic           en_q, ie_q, af_q, rmp_q, pend_q, freq_q;
  logic [3:0]     flags_q, flags_n, base_flags;
  logic [2:0]     code_q, code_n, base_code;
  logic [1:0]     lvl_q, lvl_n, base_lvl;
  logic [IAW-1:0] addr_q, addr_n, base_addr;
  logic           start, clr;

  // a new flush may start when none is pending or the pending one finishes now
  assign start = wr_ctrl & wdata[B_FLUSH] & (~pend_q | flush_done);
  assign clr   = wr_stat & (wdata == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; ie_q <= 1'b0; af_q <= 1'b0; rmp_q <= 1'b0;
      pend_q <= 1'b0; freq_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata[B_EN];
        ie_q  <= wdata[B_IE];
        af_q  <= wdata[B_AF];
        rmp_q <= wdata[B_RMP];
      end
      pend_q <= (pend_q & ~flush_done) | start;
      freq_q <= start;
    end
  end

  always_comb begin
    base_flags = clr ? '0 : flags_q;
    base_code  = clr ? '0 : code_q;
    base_lvl   = clr ? '0 : lvl_q;
    base_addr  = clr ? '0 : addr_q;
    flags_n = base_flags;
    code_n  = base_code;
    lvl_n   = base_lvl;
    addr_n  = base_addr;
    if (flt_hit && (flt_kind != '0)) begin
      if (base_flags == '0) begin
        flags_n = flt_kind;
        code_n  = flt_code;
        lvl_n   = flt_level;
        addr_n  = flt_addr;
      end else begin
        flags_n = base_flags | flt_kind;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0; code_q <= '0; lvl_q <= '0; addr_q <= '0;
    end else begin
      flags_q <= flags_n; code_q <= code_n; lvl_q <= lvl_n; addr_q <= addr_n;
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[B_EN]    = en_q;
    ctrl_rd[B_FLUSH] = pend_q;
    ctrl_rd[B_IE]    = ie_q;
    ctrl_rd[B_AF]    = af_q;
    ctrl_rd[B_RMP]   = rmp_q;
  end

  assign stat_rd   = pack_status(flags_q, code_q, lvl_q);
  assign faddr_rd  = (flags_q != '0) ? addr_q : '0;
  assign flush_req = freq_q;
  assign irq_src   = ie_q & (flags_q != '0);

  // R4: request is a single-cycle pulse
  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);
  // R4: while a request pulse is out, the flush bit reads as pending
  a_r4_req_pending: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> ctrl_rd[B_FLUSH]);
  // R5: a write during a pending flush that is not finishing yields no pulse
  a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && pend_q && !flush_done) |=> !flush_req);
  // R8: zero write clears status when no fault arrives together with it
  a_r8_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !flt_hit) |=> (stat_rd == '0 && faddr_rd == '0));
  // R7: address is held while flags remain and no clear happens
  a_r7_addr_keep: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q != '0) && !clr) |=> $stable(faddr_rd));
endmodule

// File: rtl/xlat_ctx_regbank.sv
module xlat_ctx_regbank
  import xlat_ctx_pkg::*;
#(
  parameter int unsigned NCTX = 4,
  parameter int unsigned AW   = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned IAW  = 32,
  localparam int unsigned CIW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_enable,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_ready,
  output logic [NCTX-1:0] flush_req,
  input  logic [NCTX-1:0] flush_done,
  input  logic            flt_valid,
  input  logic [CIW-1:0]  flt_ctx,
  input  logic [3:0]      flt_kind,
  input  logic [2:0]      flt_code,
  input  logic [1:0]      flt_level,
  input  logic [IAW-1:0]  flt_addr,
  output logic            irq
);
  logic [NCTX-1:0] wr_ctrl, wr_stat, irq_v;
  logic [CIW-1:0]  rd_ctx;
  reg_sel_e        rd_sel;
  logic [31:0]     ctrl_rd  [NCTX];
  logic [31:0]     stat_rd  [NCTX];
  logic [IAW-1:0]  faddr_rd [NCTX];

  xlat_ctx_decode #(.NCTX(NCTX), .AW(AW)) u_dec (
    .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_write(bus_write),
    .bus_addr(bus_addr), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .rd_ctx(rd_ctx), .rd_sel(rd_sel)
  );

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    xlat_ctx_slice #(.DW(DW), .IAW(IAW)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(wr_ctrl[i]), .wr_stat(wr_stat[i]), .wdata(bus_wdata),
      .flush_done(flush_done[i]),
      .flt_hit(flt_valid && (flt_ctx == CIW'(i))),
      .flt_kind(flt_kind), .flt_code(flt_code), .flt_level(flt_level),
      .flt_addr(flt_addr),
      .ctrl_rd(ctrl_rd[i]), .stat_rd(stat_rd[i]), .faddr_rd(faddr_rd[i]),
      .flush_req(flush_req[i]), .irq_src(irq_v[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCTX; i++) begin
      if (rd_ctx == CIW'(i)) begin
        case (rd_sel)
          SEL_CTRL:  bus_rdata = DW'(ctrl_rd[i]);
          SEL_STAT:  bus_rdata = DW'(stat_rd[i]);
          SEL_FADDR: bus_rdata = DW'(faddr_rd[i]);
          default:   bus_rdata = '0;
        endcase
      end
    end
  end

  assign bus_ready = 1'b1;
  assign irq       = |irq_v;

  // R10: interrupt can only rise after a fault record or a control write
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(flt_valid) || $past(|wr_ctrl)));
  // R10: a zero status write to every asserting context drops the interrupt
  a_r10_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ((irq_v & ~wr_stat) == '0) && (bus_wdata == '0) && !flt_valid && (wr_ctrl == '0))
    |=> !irq);
endmodule

// File: tb/sim_xlat_ctx_regbank.sv
`timescale 1ns/1ps
module sim_xlat_ctx_regbank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_enable = 0, bus_write = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [3:0]  flush_req;
  logic [3:0]  flush_done = '0;
  logic        flt_valid = 0;
  logic [1:0]  flt_ctx = '0;
  logic [3:0]  flt_kind = '0;
  logic [2:0]  flt_code = '0;
  logic [1:0]  flt_level = '0;
  logic [31:0] flt_addr = '0;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  string       q_tag[$];
  logic [31:0] q_exp[$];

  always #5 clk = ~clk;

  xlat_ctx_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .flush_req(flush_req),
    .flush_done(flush_done), .flt_valid(flt_valid), .flt_ctx(flt_ctx),
    .flt_kind(flt_kind), .flt_code(flt_code), .flt_level(flt_level),
    .flt_addr(flt_addr), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stv(logic [3:0] f, logic [2:0] c, logic [1:0] l);
    return {18'd0, l, 1'b0, c, 3'd0, f[3], 1'b0, f[2:0]};
  endfunction

  // monitor: pops expected read data during each read access phase
  always @(negedge clk) begin
    if (bus_sel && bus_enable && !bus_write) begin
      if (q_exp.size() == 0) check("scoreboard underflow", bus_rdata, 32'hx);
      else check(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
    end
  end

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2 bus_sel = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2 bus_enable = 1;
    @(posedge clk); #2 bus_sel = 0; bus_enable = 0; bus_write = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, logic [31:0] exp, string tag);
    q_tag.push_back(tag); q_exp.push_back(exp);
    @(posedge clk); #2 bus_sel = 1; bus_write = 0; bus_addr = a;
    @(posedge clk); #2 bus_enable = 1;
    @(posedge clk); #2 bus_sel = 0; bus_enable = 0;
  endtask

  task automatic done_pulse(int c);
    @(posedge clk); #2 flush_done[c] = 1;
    @(posedge clk); #2 flush_done = '0;
  endtask

  task automatic fault(logic [1:0] c, logic [3:0] k, logic [2:0] code, logic [1:0] l, logic [31:0] a);
    @(posedge clk); #2 flt_valid = 1; flt_ctx = c; flt_kind = k; flt_code = code;
    flt_level = l; flt_addr = a;
    @(posedge clk); #2 flt_valid = 0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 flush_req", {28'd0, flush_req}, 0);
    bus_rd(8'h00, 0, "R1 ctrl ctx0");
    bus_rd(8'hA0, 0, "R1 status ctx2");
    bus_rd(8'hF0, 0, "R1 faddr ctx3");

    // R3 stored bits, R2 decode of context and offsets
    bus_wr(8'h40, 32'hFFFF_FFFD);
    bus_rd(8'h40, 32'h0003_0005, "R3 ctrl ctx1 readback");
    bus_rd(8'h00, 0, "R2 ctx0 untouched");
    bus_wr(8'h44, 32'hFFFF_FFFF);
    bus_rd(8'h44, 0, "R2 unmapped offset reads 0");
    bus_rd(8'h40, 32'h0003_0005, "R2 unmapped write no effect");
    check("R2 no flush from unmapped write", {28'd0, flush_req}, 0);

    // R4 flush handshake
    bus_wr(8'h80, 32'h2);
    #1 check("R4 flush_req pulse", {28'd0, flush_req}, 32'h4);
    @(posedge clk); #1 check("R4 flush_req single", {28'd0, flush_req}, 0);
    bus_rd(8'h80, 32'h2, "R4 flush bit pending");
    // R5 second request while pending
    bus_wr(8'h80, 32'h3);
    #1 check("R5 no second pulse", {28'd0, flush_req}, 0);
    bus_rd(8'h80, 32'h3, "R5 still pending");
    done_pulse(2);
    bus_rd(8'h80, 32'h1, "R4 flush bit self-clears");

    // R11 zero write during pending flush
    bus_wr(8'h80, 32'h2);
    bus_wr(8'h80, 32'h0);
    bus_rd(8'h80, 32'h2, "R11 enables off, flush kept");
    done_pulse(2);
    bus_rd(8'h80, 32'h0, "R11 fully disabled");

    // R6 first fault capture, R10 irq
    bus_wr(8'hC0, 32'h4);
    fault(2'd3, 4'b0001, 3'd1, 2'd2, 32'h1234_5000);
    #1 check("R10 irq on with enable", {31'd0, irq}, 1);
    bus_rd(8'hE0, stv(4'b0001, 3'd1, 2'd2), "R6 status fields");
    bus_rd(8'hF0, 32'h1234_5000, "R6 fault address");
    // R7 second fault accumulates
    fault(2'd3, 4'b0010, 3'd4, 2'd1, 32'hDEAD_0000);
    bus_rd(8'hE0, stv(4'b0011, 3'd1, 2'd2), "R7 flags OR, code/level kept");
    bus_rd(8'hF0, 32'h1234_5000, "R7 address kept");
    // R8 nonzero write ignored, zero write clears
    bus_wr(8'hE0, 32'h5);
    bus_rd(8'hE0, stv(4'b0011, 3'd1, 2'd2), "R8 nonzero write ignored");
    bus_wr(8'hE0, 32'h0);
    bus_rd(8'hE0, 0, "R8 zero write clears");
    bus_rd(8'hF0, 0, "R9 address reads 0 when clear");
    #1 check("R10 irq off after clear", {31'd0, irq}, 0);

    // R10 enable gating on ctx0, R6 other flags
    fault(2'd0, 4'b1100, 3'd5, 2'd0, 32'h0000_F00C);
    #1 check("R10 irq off without enable", {31'd0, irq}, 0);
    bus_rd(8'h20, stv(4'b1100, 3'd5, 2'd0), "R6 abort and multi-hit");
    bus_wr(8'h00, 32'h4);
    #1 check("R10 irq on after enable", {31'd0, irq}, 1);
    bus_wr(8'h20, 32'h0);
    #1 check("R10 irq off after ctx0 clear", {31'd0, irq}, 0);

    repeat (3) @(posedge clk);
    if (q_exp.size() != 0) check("scoreboard drained", q_exp.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule